// File: doc/BRIEF.md
# Transponder Power-Up Initialization Sequencer

This block controls the start-up of a passive low-frequency transponder. It runs on the clock recovered from the reader field. When the power-on reset is released, it enters a configuration phase of fixed length. In that phase it fetches configuration block 0 from the non-volatile memory interface and keeps the load-damping output active. The loaded word can request a long extra hold, and during that hold damping stays on.

At the end of initialization the block raises a steady read-mode enable and gives a one-clock start pulse to the modulation encoder. It also presents the captured configuration word, which supplies the encoder's parameters. A field gap seen at any time before read mode restarts the whole sequence from the beginning. After read mode has been entered, a field gap is only passed on to downstream logic.

Top module: `tag_init_seq`

## Requirements
- R1: While `rst_n` is low, `damping` and `init_busy` are 1, and `read_mode` and `read_mode_start` are 0.
- R2: During the configuration phase, until a word has been accepted, `mem_req` is 1 with `mem_addr` = 0. A word is accepted on a clock edge where `mem_req` and `mem_valid` are both 1. Its 32 bits then appear on `cfg_word`, and the request is withdrawn.
- R3: The configuration phase lasts 192 clocks. If the accepted word has bit 24 clear, `read_mode` is 1 after exactly 192 rising edges counted from reset release.
- R4: If the accepted word has bit 24 set, a delay of 8190 clocks follows, so `read_mode` rises after exactly 8382 edges.
- R5: `damping` and `init_busy` are 1 in every cycle before read mode and 0 in read mode.
- R6: `read_mode_start` is a single-cycle pulse, high only in the first cycle that `read_mode` is 1.
- R7: A `field_gap` sampled in either phase restarts the configuration phase. Read mode then follows 192 edges after that edge, or 8382 edges when bit 24 is set. A gap outranks a phase ending on the same edge and a `mem_valid` on the same edge, and a fresh block read is requested.
- R8: In read mode a `field_gap` does not restart initialization, and `gap_out` follows `field_gap`. Before read mode, `gap_out` is 0.
- R9: If no word is accepted before the configuration phase ends, no extra delay is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered field clock |
| rst_n | input | 1 | Power-on reset, active low, released synchronously |
| field_gap | input | 1 | Field gap detected |
| mem_valid | input | 1 | Memory read data valid strobe |
| mem_data | input | 32 | Memory read data |
| mem_req | output | 1 | Block read request |
| mem_addr | output | 3 | Block address of the request |
| damping | output | 1 | Load damping enable |
| init_busy | output | 1 | Initialization in progress |
| read_mode | output | 1 | Regular-read modulation enable |
| read_mode_start | output | 1 | One-clock pulse on entry to read mode |
| cfg_word | output | 32 | Captured configuration word for the encoder |
| gap_out | output | 1 | Field gap passed downstream in read mode |

## Verification
Two pairs of events can fall on the same edge. A field gap can arrive on the edge that would end a phase, and a memory valid strobe can coincide with a gap. The bench forces the first pair directly by placing a gap on edge 192 and on edge 8382, and it expects the sequence to restart with no read-mode entry. Random gap positions and random memory latencies cover the second pair, and the run is judged by the read-mode entry edge, which the bench recomputes from the restart position.

// File: rtl/tag_init_pkg.sv
package tag_init_pkg;
  typedef enum logic [1:0] {
    PH_CFG   = 2'd0,
    PH_DELAY = 2'd1,
    PH_READ  = 2'd2
  } phase_e;
endpackage

// File: rtl/init_timer.sv
module init_timer #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign done = run && (cnt_q == limit);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (run) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              restart,
  input  logic              mem_valid,
  input  logic [DATA_W-1:0] mem_data,
  output logic              mem_req,
  output logic              loaded,
  output logic [DATA_W-1:0] cfg_word
);
  logic              loaded_q, loaded_d;
  logic [DATA_W-1:0] cfg_q, cfg_d;
  logic              take;

  assign mem_req  = active && !loaded_q;
  assign take     = mem_req && mem_valid && !restart;
  assign loaded   = loaded_q;
  assign cfg_word = cfg_q;

  always_comb begin
    loaded_d = loaded_q;
    cfg_d    = cfg_q;
    if (restart) begin
      loaded_d = 1'b0;
    end else if (take) begin
      loaded_d = 1'b1;
      cfg_d    = mem_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded_q <= 1'b0;
      cfg_q    <= '0;
    end else begin
      loaded_q <= loaded_d;
      cfg_q    <= cfg_d;
    end
  end
endmodule

// File: rtl/tag_init_seq.sv
module tag_init_seq
  import tag_init_pkg::*;
#(
  parameter int CFG_CLKS   = 192,
  parameter int DELAY_CLKS = 8190,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 3,
  parameter int DELAY_BIT  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              field_gap,
  input  logic              mem_valid,
  input  logic [DATA_W-1:0] mem_data,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              damping,
  output logic              init_busy,
  output logic              read_mode,
  output logic              read_mode_start,
  output logic [DATA_W-1:0] cfg_word,
  output logic              gap_out
);
  localparam int MAX_CLKS = (CFG_CLKS > DELAY_CLKS) ? CFG_CLKS : DELAY_CLKS;
  localparam int CNT_W    = $clog2(MAX_CLKS);

  phase_e           ph_q, ph_d;
  logic             start_q, start_d;
  logic             in_init, restart, done, loaded, delay_sel;
  logic [CNT_W-1:0] limit;

  assign in_init   = (ph_q != PH_READ);
  assign restart   = field_gap && in_init;
  assign limit     = (ph_q == PH_CFG) ? CNT_W'(CFG_CLKS - 1) : CNT_W'(DELAY_CLKS - 1);
  assign delay_sel = loaded && cfg_word[DELAY_BIT];

  init_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (in_init),
    .clr   (restart || done),
    .limit (limit),
    .done  (done)
  );

  cfg_loader #(.DATA_W(DATA_W)) u_loader (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (ph_q == PH_CFG),
    .restart   (restart),
    .mem_valid (mem_valid),
    .mem_data  (mem_data),
    .mem_req   (mem_req),
    .loaded    (loaded),
    .cfg_word  (cfg_word)
  );

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_CFG: begin
        if (restart)   ph_d = PH_CFG;
        else if (done) ph_d = delay_sel ? PH_DELAY : PH_READ;
      end
      PH_DELAY: begin
        if (restart)   ph_d = PH_CFG;
        else if (done) ph_d = PH_READ;
      end
      default: ph_d = PH_READ;
    endcase
    start_d = in_init && (ph_d == PH_READ);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_CFG;
      start_q <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      start_q <= start_d;
    end
  end

  assign mem_addr        = '0;
  assign damping         = in_init;
  assign init_busy       = in_init;
  assign read_mode       = !in_init;
  assign read_mode_start = start_q;
  assign gap_out         = field_gap && !in_init;
endmodule

// File: rtl/tag_init_seq_chk.sv
module tag_init_seq_chk #(
  parameter int CFG_CLKS   = 192,
  parameter int DELAY_CLKS = 8190,
  parameter int ADDR_W     = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              field_gap,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              damping,
  input logic              init_busy,
  input logic              read_mode,
  input logic              read_mode_start,
  input logic              gap_out
);
  localparam int LIMIT = CFG_CLKS + DELAY_CLKS;
  int unsigned busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      busy_run <= 0;
    else if (field_gap || read_mode) busy_run <= 0;
    else                             busy_run <= busy_run + 1;
  end

  a_r2_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr == '0));
  a_r4_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run <= LIMIT);
  a_r5_damp_pre_read: assert property (@(posedge clk) disable iff (!rst_n)
    read_mode |-> (!damping && !init_busy));
  a_r6_pulse_once: assert property (@(posedge clk) disable iff (!rst_n)
    read_mode_start |=> !read_mode_start);
  a_r6_pulse_entry: assert property (@(posedge clk) disable iff (!rst_n)
    read_mode_start |-> read_mode);
  a_r7_gap_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (field_gap && init_busy) |=> (init_busy && mem_req));
  a_r8_read_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    read_mode |=> read_mode);
  a_r8_gap_pass: assert property (@(posedge clk) disable iff (!rst_n)
    gap_out |-> (read_mode && field_gap));
endmodule

bind tag_init_seq tag_init_seq_chk #(
  .CFG_CLKS(CFG_CLKS), .DELAY_CLKS(DELAY_CLKS), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .field_gap(field_gap), .mem_req(mem_req),
  .mem_addr(mem_addr), .damping(damping), .init_busy(init_busy),
  .read_mode(read_mode), .read_mode_start(read_mode_start), .gap_out(gap_out)
);

// File: tb/sim_tag_init_seq.sv
`timescale 1ns/1ps
module sim_tag_init_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        field_gap = 1'b0;
  logic        mem_valid = 1'b0;
  logic [31:0] mem_data = '0;
  logic        mem_req, damping, init_busy, read_mode, read_mode_start, gap_out;
  logic [2:0]  mem_addr;
  logic [31:0] cfg_word;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit resp_en = 1;
  int lat = 0;
  int mcnt = 0;
  logic [31:0] cfg_data = '0;

  always #2 clk = ~clk;

  tag_init_seq u0 (
    .clk(clk), .rst_n(rst_n), .field_gap(field_gap), .mem_valid(mem_valid),
    .mem_data(mem_data), .mem_req(mem_req), .mem_addr(mem_addr),
    .damping(damping), .init_busy(init_busy), .read_mode(read_mode),
    .read_mode_start(read_mode_start), .cfg_word(cfg_word), .gap_out(gap_out)
  );

  // memory model: answers a request after lat cycles with a one-cycle strobe
  always @(negedge clk) begin
    if (!rst_n) begin
      mcnt = 0; mem_valid = 1'b0;
    end else if (mem_valid) begin
      mem_valid = 1'b0;
    end else if (mem_req && resp_en) begin
      if (mcnt >= lat) begin
        mem_valid = 1'b1; mem_data = cfg_data; mcnt = 0;
      end else mcnt++;
    end else mcnt = 0;
  end

  function automatic int exp_len(bit dly, bit resp);
    return 192 + ((dly && resp) ? 8190 : 0);
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // gap_at: edge number (from reset release) that samples a gap, or -1
  task automatic trial(bit dly, bit resp, int l, int gap_at);
    int n = 0;
    int starts = 0;
    int expn;
    bit bad5 = 0, bad2 = 0, bad8 = 0;
    resp_en = resp; lat = l;
    cfg_data = $urandom;
    cfg_data[24] = dly;
    expn = (gap_at > 0) ? gap_at + exp_len(dly, resp) : exp_len(dly, resp);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(damping && init_busy && !read_mode && !read_mode_start, "R1", read_mode, 0);
    rst_n = 1'b1;
    while (n < 20000) begin
      if (n + 1 == gap_at) field_gap = 1'b1;
      @(posedge clk); #1;
      n++;
      field_gap = 1'b0;
      if (read_mode_start) starts++;
      if (read_mode) break;
      if (!damping || !init_busy) bad5 = 1;
      if (gap_out) bad8 = 1;
      if (mem_req && mem_addr != 3'd0) bad2 = 1;
    end
    chk(n == expn, (gap_at > 0) ? "R7" : (dly && resp ? "R4" : (resp ? "R3" : "R9")), n, expn);
    chk(!bad5, "R5", bad5, 0);
    chk(!bad2, "R2", bad2, 0);
    chk(!bad8, "R8", bad8, 0);
    chk(read_mode_start && starts == 1, "R6", starts, 1);
    if (resp) chk(cfg_word == cfg_data, "R2", cfg_word, cfg_data);
    @(posedge clk); #1;
    chk(!read_mode_start && read_mode, "R6", read_mode_start, 0);
    chk(!damping && !init_busy, "R5", damping, 0);
    field_gap = 1'b1;
    repeat (3) begin
      @(posedge clk); #1;
      chk(read_mode && gap_out && !damping, "R8", read_mode, 1);
    end
    field_gap = 1'b0;
    @(posedge clk); #1;
    chk(!gap_out, "R8", gap_out, 0);
  endtask

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // directed corners
    trial(0, 1, 10, -1);          // R3
    trial(1, 1, 40, -1);          // R4
    trial(1, 0, 0, -1);           // R9
    trial(0, 1, 5, 192);          // R7 gap on config end edge
    trial(1, 1, 5, 8382);         // R7 gap on delay end edge
    trial(1, 1, 20, 300);         // R7 gap in delay phase
    trial(0, 1, 0, 1);            // R7 gap on first edge (same edge as strobe)
    // random
    for (int t = 0; t < 8; t++) begin
      bit d = $urandom % 2;
      int l = $urandom % 150;
      int g = ($urandom % 3 == 0) ? -1 : 1 + ($urandom % exp_len(d, 1'b1));
      trial(d, 1'b1, l, g);
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule